// File: doc/BRIEF.md
# Port access strobe generator

This block sits between a processor's internal bus and an 8-bit general-purpose port. It holds the port output register and the byte returned to the processor on a port read. When a strobe-enable bit from the processor's control register is set, it also drives two active-low pins that tell external logic when an access has happened.

A write loads the output register on the access edge. The write strobe then goes low two cycles later, which tells the outside that fresh data is on the port. A read captures the port pins on the access edge. The read strobe goes low three cycles later. It is only a hint to the peripheral that the byte has been consumed and the next one may be prepared. Nothing is captured while it is low.

The read and write channels each run their own delay counter. A new access of the same kind restarts its channel's sequence. Clearing the enable bit releases both strobes at once and cancels any pulse still pending.

Top module: `port_strobe_gen`

## Requirements
- R1: While rst_n is low at a clock edge, the block resets. After that edge wr_n and rd_n are 1, port_out is 0x00 and cpu_rdata is 0x00.
- R2: A clock edge with cpu_wr high loads cpu_wdata into port_out. Without cpu_wr, port_out keeps its value. This holds whatever the state of stb_en.
- R3: Call the edge that samples an enabled write edge 0. wr_n is 0 after edges 2 and 3 and is 1 after edge 4. A pulse is therefore exactly two cycles long.
- R4: A clock edge with cpu_rd high captures pins_in into cpu_rdata. Without cpu_rd, cpu_rdata keeps its value. This holds whatever the state of stb_en.
- R5: Call the edge that samples an enabled read edge 0. rd_n is 0 after edges 3 and 4 and is 1 after edge 5.
- R6: While stb_en is 0, wr_n and rd_n are 1. Accesses made while stb_en is 0 produce no pulse later on.
- R7: If stb_en goes to 0 while a sequence is pending or running, the sequence is cancelled. Setting stb_en to 1 again does not bring back the lost pulse.
- R8: A new access of the same kind restarts that channel's sequence from the new access edge. The strobe is 1 after the restarting edge, and low periods are never merged.
- R9: The read and write channels are independent. A read and a write at any spacing, including the same edge, each give their own pulse at their own offsets.
- R10: Changes on pins_in after a read edge do not change cpu_rdata, including while rd_n is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stb_en | input | 1 | Strobe enable bit from the processor control register |
| cpu_wr | input | 1 | One-cycle port write access |
| cpu_rd | input | 1 | One-cycle port read access |
| cpu_wdata | input | 8 | Write data from the processor |
| pins_in | input | 8 | Port pin values |
| port_out | output | 8 | Port output register |
| cpu_rdata | output | 8 | Byte captured at the last read access |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
A delay counter that starts at the wrong value, or that ends at the wrong count, moves or stretches a strobe. This shows on wr_n or rd_n within five cycles of the access. A counter that is not cleared on restart or on disable leaves a pulse that appears where the cycle-by-cycle expectation has none. A data register loaded on the wrong edge shows on port_out or cpu_rdata after the next edge. On the read side the cause is that pins_in changes every cycle in the bench.

// File: rtl/port_strobe_pkg.sv
// Package: default timing and width constants shared by the strobe generator.
// Assumes one clock domain; all values are counted in clock cycles.
package port_strobe_pkg;
    localparam int DATA_W_DEF   = 8;
    localparam int WR_LEAD_DEF  = 2;
    localparam int RD_LEAD_DEF  = 3;
    localparam int PULSE_W_DEF  = 2;
    localparam int NUM_CH       = 2;
    localparam int CH_WR        = 0;
    localparam int CH_RD        = 1;
endpackage

// File: rtl/strobe_seq.sv
// strobe_seq: one delayed-pulse channel.
// The counter loads 1 on an accepted trigger and counts up to LEAD + WIDTH,
// then returns to 0. The strobe is low while the count is above LEAD.
// A trigger during a run reloads 1 (restart, no merge). A low enable clears
// the count and forces the strobe high in the same cycle.
// Assumes a one-cycle trigger pulse and LEAD >= 1, WIDTH >= 1.
module strobe_seq #(
    parameter int LEAD  = 2,
    parameter int WIDTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic trigger,
    output logic strobe_n
);
    localparam int LAST = LEAD + WIDTH;
    localparam int CW   = $clog2(LAST + 1);

    logic [CW-1:0] cnt;

    // Delay and pulse counter: load, advance, wrap or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!enable) begin
            cnt <= '0;
        end else if (trigger) begin
            cnt <= CW'(1);
        end else if (cnt != '0) begin
            cnt <= (cnt == CW'(LAST)) ? '0 : cnt + CW'(1);
        end
    end

    // Strobe decode, gated by the enable so clearing it releases at once.
    always_comb begin
        strobe_n = !(enable && (cnt > CW'(LEAD)));
    end
endmodule

// File: rtl/port_data_regs.sv
// port_data_regs: the port output register and the read capture register.
// Both load on their access pulse only and ignore the strobe enable.
// Assumes pins_in is already synchronous to clk.
module port_data_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_acc,
    input  logic              rd_acc,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] pins,
    output logic [DATA_W-1:0] out_q,
    output logic [DATA_W-1:0] cap_q
);
    // Output register: loads write data on a write access.
    always_ff @(posedge clk) begin
        if (!rst_n)      out_q <= '0;
        else if (wr_acc) out_q <= wdata;
    end

    // Read capture: samples the pins on the read access edge only.
    always_ff @(posedge clk) begin
        if (!rst_n)      cap_q <= '0;
        else if (rd_acc) cap_q <= pins;
    end
endmodule

// File: rtl/port_strobe_gen.sv
// port_strobe_gen: top of the port access strobe generator.
// It holds the port data registers and two independent strobe channels:
// the write channel has a lead of WR_LEAD cycles and the read channel a lead
// of RD_LEAD cycles. Each channel pulses low for PULSE_W cycles.
// Assumes cpu_wr and cpu_rd are single-cycle pulses in the clk domain.
module port_strobe_gen
    import port_strobe_pkg::*;
#(
    parameter int DATA_W  = DATA_W_DEF,
    parameter int WR_LEAD = WR_LEAD_DEF,
    parameter int RD_LEAD = RD_LEAD_DEF,
    parameter int PULSE_W = PULSE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_en,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [DATA_W-1:0] pins_in,
    output logic [DATA_W-1:0] port_out,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              rd_n,
    output logic              wr_n
);
    logic [NUM_CH-1:0] trig_v;
    logic [NUM_CH-1:0] stb_n_v;

    // Channel trigger mapping.
    always_comb begin
        trig_v[CH_WR] = cpu_wr;
        trig_v[CH_RD] = cpu_rd;
    end

    port_data_regs #(.DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_acc (cpu_wr),
        .rd_acc (cpu_rd),
        .wdata  (cpu_wdata),
        .pins   (pins_in),
        .out_q  (port_out),
        .cap_q  (cpu_rdata)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam int LEAD = (ch == CH_WR) ? WR_LEAD : RD_LEAD;
        strobe_seq #(.LEAD(LEAD), .WIDTH(PULSE_W)) u_seq (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable   (stb_en),
            .trigger  (trig_v[ch]),
            .strobe_n (stb_n_v[ch])
        );
    end

    assign wr_n = stb_n_v[CH_WR];
    assign rd_n = stb_n_v[CH_RD];
endmodule

// File: rtl/port_strobe_chk.sv
// port_strobe_chk: port-level properties of port_strobe_gen.
// Assumes the default leads (write 2, read 3) and a pulse width of 2.
module port_strobe_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stb_en,
    input logic       cpu_wr,
    input logic       cpu_rd,
    input logic [7:0] cpu_wdata,
    input logic [7:0] pins_in,
    input logic [7:0] port_out,
    input logic [7:0] cpu_rdata,
    input logic       rd_n,
    input logic       wr_n
);
    // R2
    port_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(cpu_wr) |-> port_out == $past(cpu_wdata));
    // R2
    port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(cpu_wr) |-> $stable(port_out));
    // R4
    rdata_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(cpu_rd) |-> cpu_rdata == $past(pins_in));
    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(cpu_rd) |-> $stable(cpu_rdata));
    // R3
    wr_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |-> $past(cpu_wr, 3));
    // R5
    rd_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> $past(cpu_rd, 4));
    // R3
    wr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) && !cpu_wr |=> (!wr_n || !stb_en));
    // R8
    wr_no_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n && $past(!wr_n) |=> wr_n);
    // R8
    rd_no_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n && $past(!rd_n) |=> rd_n);
    // R6
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_en |-> (rd_n && wr_n));
endmodule

bind port_strobe_gen port_strobe_chk chk_i (.*);

// File: tb/port_strobe_gen_test.sv
// Bench for port_strobe_gen: runs per-cycle stimulus schedules and compares
// every cycle with an arithmetic expectation.
module port_strobe_gen_test;
    localparam int LEN = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stb_en = 1'b0;
    logic       cpu_wr = 1'b0;
    logic       cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] pins_in = 8'h00;
    logic [7:0] port_out, cpu_rdata;
    logic       rd_n, wr_n;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    bit       wr_s [LEN];
    bit       rd_s [LEN];
    bit       en_s [LEN];
    bit [7:0] wd_s [LEN];
    bit [7:0] pin_s[LEN];
    bit [7:0] exp_port = 8'h00;
    bit [7:0] exp_rd = 8'h00;

    always #5 clk = ~clk;

    port_strobe_gen uut (
        .clk(clk), .rst_n(rst_n), .stb_en(stb_en), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .pins_in(pins_in),
        .port_out(port_out), .cpu_rdata(cpu_rdata), .rd_n(rd_n), .wr_n(wr_n)
    );

    task automatic check(input string tag, input int act, input int exp_v);
        tests++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    task automatic clear_sched(input int seed);
        for (int k = 0; k < LEN; k++) begin
            wr_s[k] = 1'b0; rd_s[k] = 1'b0; en_s[k] = 1'b1;
            wd_s[k]  = 8'(seed * 29 + k * 53 + 7);
            pin_s[k] = 8'(seed * 71 + k * 13 + 3);
        end
    endtask

    // Expected strobe level after edge k: low at offsets lead and lead+1
    // from the last enabled trigger (R3 and R5), if the enable held (R6, R7).
    function automatic bit exp_low(input int k, input bit is_rd);
        int lead = is_rd ? 3 : 2;
        int w = -1;
        for (int j = k; j >= 0; j--) begin
            if ((is_rd ? rd_s[j] : wr_s[j]) && en_s[j]) begin
                w = j;
                break;
            end
        end
        if (w < 0) return 1'b0;
        for (int j = w; j <= k; j++) if (!en_s[j]) return 1'b0;
        return (k - w >= lead) && (k - w <= lead + 1);
    endfunction

    task automatic run_sched(input string wtag, input string rtag);
        for (int k = 0; k < LEN; k++) begin
            cpu_wr = wr_s[k]; cpu_rd = rd_s[k]; stb_en = en_s[k];
            cpu_wdata = wd_s[k]; pins_in = pin_s[k];
            if (wr_s[k]) exp_port = wd_s[k];
            if (rd_s[k]) exp_rd = pin_s[k];
            @(posedge clk);
            @(negedge clk);
            check($sformatf("%s wr_n cycle %0d", wtag, k), int'(wr_n), int'(!exp_low(k, 1'b0)));
            check($sformatf("%s rd_n cycle %0d", rtag, k), int'(rd_n), int'(!exp_low(k, 1'b1)));
            check($sformatf("R2 port_out cycle %0d", k), int'(port_out), int'(exp_port));
            check($sformatf("R4/R10 cpu_rdata cycle %0d", k), int'(cpu_rdata), int'(exp_rd));
        end
        cpu_wr = 1'b0; cpu_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 wr_n", int'(wr_n), 1);
        check("R1 rd_n", int'(rd_n), 1);
        check("R1 port_out", int'(port_out), 0);
        check("R1 cpu_rdata", int'(cpu_rdata), 0);
        rst_n = 1'b1;

        // R3 single write, R5 single read with moving pins (R10)
        clear_sched(1); wr_s[0] = 1'b1; run_sched("R3", "R5");
        clear_sched(2); rd_s[0] = 1'b1; run_sched("R3", "R5 R10");

        // R9 write then read at every gap, both orders
        for (int g = 0; g < 7; g++) begin
            clear_sched(10 + g); wr_s[1] = 1'b1; rd_s[1 + g] = 1'b1;
            run_sched("R9", "R9");
            clear_sched(20 + g); rd_s[1] = 1'b1; wr_s[1 + g] = 1'b1;
            run_sched("R9", "R9");
        end

        // R8 restart at every gap
        for (int g = 1; g < 7; g++) begin
            clear_sched(30 + g); wr_s[0] = 1'b1; wr_s[g] = 1'b1;
            run_sched("R8", "R8");
            clear_sched(40 + g); rd_s[0] = 1'b1; rd_s[g] = 1'b1;
            run_sched("R8", "R8");
        end

        // R6 enable clear: accesses give no pulse, data still moves
        clear_sched(50);
        for (int k = 0; k < LEN; k++) en_s[k] = (k >= 8);
        wr_s[1] = 1'b1; rd_s[2] = 1'b1; wr_s[5] = 1'b1; rd_s[6] = 1'b1;
        run_sched("R6", "R6");

        // R7 enable dropped for one cycle at every point of a sequence
        for (int d = 1; d < 6; d++) begin
            clear_sched(60 + d); wr_s[0] = 1'b1; rd_s[0] = 1'b1; en_s[d] = 1'b0;
            run_sched("R7", "R7");
        end

        // R1 reset in the middle of a pulse
        clear_sched(70); wr_s[0] = 1'b1; rd_s[0] = 1'b1;
        stb_en = 1'b1; cpu_wr = 1'b1; cpu_rd = 1'b1; cpu_wdata = 8'h5A;
        @(posedge clk); @(negedge clk);
        cpu_wr = 1'b0; cpu_rd = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 wr_n after mid reset", int'(wr_n), 1);
        check("R1 rd_n after mid reset", int'(rd_n), 1);
        check("R1 port_out after mid reset", int'(port_out), 0);
        rst_n = 1'b1;
        repeat (5) begin
            @(posedge clk); @(negedge clk);
            check("R1 no pulse after reset wr_n", int'(wr_n), 1);
            check("R1 no pulse after reset rd_n", int'(rd_n), 1);
        end

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule